// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block produces four groups of gated clock outputs from one reference clock running at twice the CPU clock rate. The groups are the CPU clocks, the SDRAM clocks (in phase with the CPU clocks), the PCI clocks and a set of fixed reference clocks. The outputs are registered waveforms cut from one shared phase counter. Any output can therefore be suppressed one whole period at a time, and no partial pulse can appear.

Two active-low request pins can stop the outputs. The CPU-halt request acts on the CPU group alone. The power-down request acts on every group, and every output is then held low. Each request passes through a two-stage synchronizer. A countdown measured in CPU cycles then runs before the outputs stop. A second countdown runs before they resume. A strap input decides whether the request pins are used at all. Power-down dominates: while it is in force, releasing the CPU-halt request does not bring the CPU clocks back.

Top module: `clk_stop_ctrl`

## Requirements
- R1: After reset with no request, the clocks run freely. CPU and SDRAM outputs have a period of 2 reference cycles and are high for 1. PCI outputs have a period of 4 and are high for 2. Fixed outputs have a period of 8 and are high for 4. All outputs rise together at the phase-counter wrap.
- R2: With `strap_pins_i` = 1, driving `cpu_halt_ni` low stops every CPU output low after 23 to 26 further CPU pulses. This is a 23-cycle countdown plus synchronizer delay.
- R3: Raising `cpu_halt_ni` again gives a first CPU rising edge 46 to 54 reference cycles later. The resumed pulses are full width.
- R4: The CPU-halt request has no effect on the SDRAM, PCI and fixed outputs.
- R5: With `strap_pins_i` = 1, driving `pwr_dn_ni` low stops the CPU outputs after 24 to 27 further pulses. Afterwards every output of every group is held low.
- R6: Releasing `pwr_dn_ni` restarts the SDRAM outputs within 2*PD_START_LAT to 2*PD_START_LAT+8 reference cycles. PD_START_LAT is 48 CPU cycles by default.
- R7: With `strap_pins_i` = 0, both request pins have no effect. The outputs keep running and `cpu_halted_o` stays 0.
- R8: While power-down holds, neither releasing nor asserting CPU-halt starts the CPU outputs. When power-down ends while CPU-halt is still low, the CPU outputs stay low and the other groups resume.
- R9: Every high pulse has its full width: 1, 2 and 4 reference cycles for the CPU, PCI and fixed groups. All CPU outputs are identical, and a high CPU output implies a high SDRAM output.
- R10: `cpu_halted_o` is 0 during and after reset. It is 1 once the CPU outputs have been stopped by either request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, twice the CPU clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_pins_i | input | 1 | 1 = request pins are used, 0 = they are ignored |
| cpu_halt_ni | input | 1 | Active-low CPU clock halt request, asynchronous |
| pwr_dn_ni | input | 1 | Active-low power-down request, asynchronous |
| cpu_clk_o | output | N_CPU | Gated CPU clocks |
| sdram_clk_o | output | N_SDRAM | Gated SDRAM clocks, in phase with the CPU clocks |
| pci_clk_o | output | N_PCI | Gated PCI clocks |
| fix_clk_o | output | N_FIX | Gated fixed-rate reference clocks |
| cpu_halted_o | output | 1 | 1 while the CPU clock enable is withdrawn |

## Verification
The assertions assume that a power-down request stays stable for longer than the outputs need to drain. They also assume the strap input changes only while both request pins are high. The pulse-width and grouping properties additionally rely on the stop and restart countdowns being longer than a few reference cycles, which holds for the default latencies. The stimulus changes the request pins only on falling reference edges. It holds each request level for at least 80 cycles, and it moves the strap only with the pins released. Latency windows in the checks therefore absorb only the synchronizer and phase uncertainty.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  typedef enum logic [1:0] {
    ST_RUN,
    ST_DRAIN,
    ST_HALT,
    ST_WAKE
  } seq_state_e;
endpackage

// File: rtl/clk_stop_sync.sv
`timescale 1ns/1ps
module clk_stop_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  // Reset to released (high) so no request is seen out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '1;
      stage2_q <= '1;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/clk_stop_seq.sv
`timescale 1ns/1ps
module clk_stop_seq
  import clk_stop_pkg::*;
#(
  parameter int STOP_LAT  = 23,
  parameter int START_LAT = 23
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,   // last reference cycle of a CPU period
  input  logic req_i,    // active-high stop request
  output logic en_o
);
  localparam int MAX_LAT = (STOP_LAT > START_LAT) ? STOP_LAT : START_LAT;
  localparam int CW      = $clog2(MAX_LAT + 1);

  seq_state_e    state_q;
  logic [CW-1:0] left_q;
  logic          en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      left_q  <= '0;
      en_q    <= 1'b1;
    end else begin
      unique case (state_q)
        ST_RUN: if (req_i) begin
          state_q <= ST_DRAIN;
          left_q  <= CW'(STOP_LAT);
        end
        ST_DRAIN: begin
          if (!req_i) state_q <= ST_RUN;
          else if (tick_i) begin
            if (left_q == CW'(1)) begin
              state_q <= ST_HALT;
              en_q    <= 1'b0;
            end else left_q <= left_q - CW'(1);
          end
        end
        ST_HALT: if (!req_i) begin
          state_q <= ST_WAKE;
          left_q  <= CW'(START_LAT);
        end
        ST_WAKE: begin
          if (req_i) state_q <= ST_HALT;
          else if (tick_i) begin
            if (left_q == CW'(1)) begin
              state_q <= ST_RUN;
              en_q    <= 1'b1;
            end else left_q <= left_q - CW'(1);
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
  parameter int LOG2 = 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [LOG2-1:0] phase_i,
  input  logic            en_i,
  output logic            clk_o
);
  logic [LOG2-1:0] phase_nxt;
  logic            boundary, high_nxt, gate_now, hold_q, out_q;

  assign phase_nxt = phase_i + LOG2'(1);
  assign boundary  = &phase_i;
  assign high_nxt  = ~phase_nxt[LOG2-1];
  // Enable is sampled only at the period boundary: whole periods or none
  assign gate_now  = boundary ? en_i : hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      hold_q <= gate_now;
      out_q  <= gate_now & high_nxt;
    end
  end

  assign clk_o = out_q;
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl #(
  parameter int N_CPU        = 4,
  parameter int N_SDRAM      = 12,
  parameter int N_PCI        = 7,
  parameter int N_FIX        = 2,
  parameter int CPU_LOG2     = 1,
  parameter int PCI_LOG2     = 2,
  parameter int FIX_LOG2     = 3,
  parameter int HALT_LAT     = 23,
  parameter int PD_STOP_LAT  = 24,
  parameter int PD_START_LAT = 48
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               strap_pins_i,
  input  logic               cpu_halt_ni,
  input  logic               pwr_dn_ni,
  output logic [N_CPU-1:0]   cpu_clk_o,
  output logic [N_SDRAM-1:0] sdram_clk_o,
  output logic [N_PCI-1:0]   pci_clk_o,
  output logic [N_FIX-1:0]   fix_clk_o,
  output logic               cpu_halted_o
);
  localparam int CNT_W = FIX_LOG2;

  logic [CNT_W-1:0] phase_q;
  logic [1:0]       pins_s;
  logic             tick, halt_req, pd_req, cpu_en, pd_en, cpu_gate_en;
  logic             cpu_g, sdram_g, pci_g, fix_g;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + CNT_W'(1);
  end

  assign tick = &phase_q[CPU_LOG2-1:0];

  clk_stop_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({pwr_dn_ni, cpu_halt_ni}),
    .sync_o (pins_s)
  );

  assign halt_req = strap_pins_i & ~pins_s[0];
  assign pd_req   = strap_pins_i & ~pins_s[1];

  clk_stop_seq #(.STOP_LAT(HALT_LAT), .START_LAT(HALT_LAT)) u_seq_cpu (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .req_i(halt_req), .en_o(cpu_en)
  );

  clk_stop_seq #(.STOP_LAT(PD_STOP_LAT), .START_LAT(PD_START_LAT)) u_seq_pd (
    .clk_i (clk_i), .rst_ni(rst_ni), .tick_i(tick), .req_i(pd_req), .en_o(pd_en)
  );

  // Power-down dominates: CPU clocks need both enables
  assign cpu_gate_en = cpu_en & pd_en;

  clk_stop_gate #(.LOG2(CPU_LOG2)) u_gate_cpu (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase_q[CPU_LOG2-1:0]),
    .en_i(cpu_gate_en), .clk_o(cpu_g)
  );
  clk_stop_gate #(.LOG2(CPU_LOG2)) u_gate_sdram (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase_q[CPU_LOG2-1:0]),
    .en_i(pd_en), .clk_o(sdram_g)
  );
  clk_stop_gate #(.LOG2(PCI_LOG2)) u_gate_pci (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase_q[PCI_LOG2-1:0]),
    .en_i(pd_en), .clk_o(pci_g)
  );
  clk_stop_gate #(.LOG2(FIX_LOG2)) u_gate_fix (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase_q[FIX_LOG2-1:0]),
    .en_i(pd_en), .clk_o(fix_g)
  );

  assign cpu_clk_o    = {N_CPU{cpu_g}};
  assign sdram_clk_o  = {N_SDRAM{sdram_g}};
  assign pci_clk_o    = {N_PCI{pci_g}};
  assign fix_clk_o    = {N_FIX{fix_g}};
  assign cpu_halted_o = ~cpu_gate_en;
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clk_stop_ctrl_chk #(
  parameter int N_CPU   = 4,
  parameter int N_SDRAM = 12,
  parameter int N_PCI   = 7,
  parameter int N_FIX   = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               pd_en_i,
  input logic [N_CPU-1:0]   cpu_clk_o,
  input logic [N_SDRAM-1:0] sdram_clk_o,
  input logic [N_PCI-1:0]   pci_clk_o,
  input logic [N_FIX-1:0]   fix_clk_o,
  input logic               cpu_halted_o
);
  a_r9_cpu_group_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(cpu_clk_o) == 0) || ($countones(cpu_clk_o) == N_CPU));

  a_r9_sdram_in_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_o[0] |-> (&sdram_clk_o));

  a_r9_cpu_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_o[0]) |=> !cpu_clk_o[0]);

  a_r9_pci_pulse_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pci_clk_o[0]) |=> pci_clk_o[0]);

  a_r9_fix_pulse_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fix_clk_o[0]) |=> fix_clk_o[0]);

  a_r5_pd_all_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_en_i && !$past(pd_en_i, 8)) |->
      (cpu_clk_o == '0 && sdram_clk_o == '0 && pci_clk_o == '0 && fix_clk_o == '0));

  a_r10_halted_when_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_en_i |-> cpu_halted_o);
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
  .N_CPU(N_CPU), .N_SDRAM(N_SDRAM), .N_PCI(N_PCI), .N_FIX(N_FIX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pd_en_i     (pd_en),
  .cpu_clk_o   (cpu_clk_o),
  .sdram_clk_o (sdram_clk_o),
  .pci_clk_o   (pci_clk_o),
  .fix_clk_o   (fix_clk_o),
  .cpu_halted_o(cpu_halted_o)
);

// File: tb/clk_stop_ctrl_tb.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb;
  localparam int N_CPU = 4, N_SDRAM = 12, N_PCI = 7, N_FIX = 2;
  localparam int HALT_LAT = 23, PD_STOP_LAT = 24, PD_START_LAT = 48;

  logic clk_i = 1'b0, rst_ni = 1'b0, strap_pins_i = 1'b1;
  logic cpu_halt_ni = 1'b1, pwr_dn_ni = 1'b1;
  logic [N_CPU-1:0]   cpu_clk_o;
  logic [N_SDRAM-1:0] sdram_clk_o;
  logic [N_PCI-1:0]   pci_clk_o;
  logic [N_FIX-1:0]   fix_clk_o;
  logic               cpu_halted_o;

  int checks = 0, errors = 0;
  int cpu_r = 0, sd_r = 0, pci_r = 0, fix_r = 0;
  int cpu_w = 0, pci_w = 0, fix_w = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  clk_stop_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .strap_pins_i(strap_pins_i),
    .cpu_halt_ni(cpu_halt_ni), .pwr_dn_ni(pwr_dn_ni),
    .cpu_clk_o(cpu_clk_o), .sdram_clk_o(sdram_clk_o), .pci_clk_o(pci_clk_o),
    .fix_clk_o(fix_clk_o), .cpu_halted_o(cpu_halted_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // Edge counters and pulse-width checks (R9), sampled on falling edges
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (cpu_clk_o[0]) begin if (cpu_w == 0) cpu_r++; cpu_w++; end
      else if (cpu_w != 0) begin check(cpu_w == 1, "R9 cpu width", cpu_w, 1); cpu_w = 0; end
      if (pci_clk_o[0]) begin if (pci_w == 0) pci_r++; pci_w++; end
      else if (pci_w != 0) begin check(pci_w == 2, "R9 pci width", pci_w, 2); pci_w = 0; end
      if (fix_clk_o[0]) begin if (fix_w == 0) fix_r++; fix_w++; end
      else if (fix_w != 0) begin check(fix_w == 4, "R9 fix width", fix_w, 4); fix_w = 0; end
      if (sdram_clk_o[0] && !$past(sdram_clk_o[0])) sd_r++;
      if (cpu_clk_o[0]) check(&sdram_clk_o && &cpu_clk_o, "R9 grouping", 0, 1);
    end
  end

  task automatic run_counts(input int win, input int e_cpu, input int e_sd,
                            input int e_pci, input int e_fix, input string req);
    int c0, s0, p0, f0;
    c0 = cpu_r; s0 = sd_r; p0 = pci_r; f0 = fix_r;
    cyc(win);
    check(cpu_r - c0 == e_cpu, {req, " cpu pulses"}, cpu_r - c0, e_cpu);
    check(sd_r - s0 == e_sd,   {req, " sdram pulses"}, sd_r - s0, e_sd);
    check(pci_r - p0 == e_pci, {req, " pci pulses"}, pci_r - p0, e_pci);
    check(fix_r - f0 == e_fix, {req, " fix pulses"}, fix_r - f0, e_fix);
  endtask

  initial begin
    int c0, n;
    // R10 reset state
    cyc(5);
    check(cpu_clk_o == 0 && sdram_clk_o == 0 && pci_clk_o == 0 && fix_clk_o == 0,
          "R10 reset outputs", 1, 0);
    check(cpu_halted_o == 0, "R10 reset status", cpu_halted_o, 0);
    rst_ni = 1'b1;
    cyc(20);
    // R1 free running
    run_counts(40, 20, 20, 10, 5, "R1");
    check(cpu_halted_o == 0, "R10 run status", cpu_halted_o, 0);

    // R7 pins ignored when strap is 0
    strap_pins_i = 1'b0; cyc(4);
    cpu_halt_ni = 1'b0; pwr_dn_ni = 1'b0; cyc(100);
    run_counts(80, 40, 40, 20, 10, "R7");
    check(cpu_halted_o == 0, "R7 status", cpu_halted_o, 0);
    cpu_halt_ni = 1'b1; pwr_dn_ni = 1'b1; cyc(4);
    strap_pins_i = 1'b1; cyc(8);

    // R2 CPU halt
    c0 = cpu_r;
    cpu_halt_ni = 1'b0;
    cyc(120);
    n = cpu_r - c0;
    check(n >= HALT_LAT && n <= HALT_LAT + 3, "R2 pulses before stop", n, HALT_LAT);
    check(cpu_clk_o == 0, "R2 cpu low", cpu_clk_o, 0);
    check(cpu_halted_o == 1, "R10 halted status", cpu_halted_o, 1);
    // R4 other groups unaffected
    run_counts(40, 0, 20, 10, 5, "R4");

    // R3 restart
    cpu_halt_ni = 1'b1;
    n = 0;
    while (!cpu_clk_o[0] && n < 300) begin cyc(1); n++; end
    check(n >= 2*HALT_LAT && n <= 2*HALT_LAT + 8, "R3 restart delay", n, 2*HALT_LAT);
    cyc(3);
    run_counts(40, 20, 20, 10, 5, "R3");

    // R5 power-down
    c0 = cpu_r;
    pwr_dn_ni = 1'b0;
    cyc(120);
    n = cpu_r - c0;
    check(n >= PD_STOP_LAT && n <= PD_STOP_LAT + 3, "R5 pulses before stop", n, PD_STOP_LAT);
    run_counts(40, 0, 0, 0, 0, "R5");
    check(cpu_halted_o == 1, "R10 pd status", cpu_halted_o, 1);

    // R8 precedence
    cpu_halt_ni = 1'b0; cyc(100);
    cpu_halt_ni = 1'b1; cyc(150);
    run_counts(40, 0, 0, 0, 0, "R8 pd holds");
    cpu_halt_ni = 1'b0; cyc(80);

    // R6 power-down release with CPU halt still asserted
    pwr_dn_ni = 1'b1;
    n = 0;
    while (!sdram_clk_o[0] && n < 400) begin cyc(1); n++; end
    check(n >= 2*PD_START_LAT && n <= 2*PD_START_LAT + 8, "R6 restart delay", n, 2*PD_START_LAT);
    cyc(3);
    run_counts(80, 0, 40, 20, 10, "R8 cpu stays halted");
    check(cpu_halted_o == 1, "R8 status", cpu_halted_o, 1);
    cpu_halt_ni = 1'b1; cyc(120);
    run_counts(40, 20, 20, 10, 5, "R3 final run");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule